// File: doc/BRIEF.md
# Byte-wide NOR flash command sequencer

This block is the device side of a small byte-wide NOR flash. It sits over its own byte array and watches single-cycle write strobes on the address and data bus. Array contents change only after a write sequence that opens with a two-write unlock and carries a valid command code. The supported operations are byte program, sector erase, chip erase and an identification mode that returns a manufacturer code and a device code.

Program can only clear bits. Erase sets every byte of a sector, or of the whole array, to 0xFF, one byte per cycle. While an operation is busy the block ignores all writes. During that time a read returns a status byte whose bit 6 flips on every read, so a host can poll for completion by comparing two reads. A reset code of 0xF0 returns the sequencer to array-read mode whenever no operation is busy.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, or after a reset pulse taken in any mode, busy_o is 0 and rdata_o is 0x00. The sequencer is idle, so the next read returns array data.
- R2: A command is taken only after 0xAA written at 0x555 and then 0x55 written at 0x2AA. These are compared on address bits [10:0]. Any other write where a sequence step is expected returns the sequencer to idle, and the writes that follow the break have no effect on the array.
- R3: After the unlock pair, 0xA0 at 0x555 arms program. The next write stores the bitwise AND of the old byte and the written byte at its address. The sequencer is idle afterwards.
- R4: After the unlock pair, the erase sequence is 0x80 at 0x555, then 0xAA at 0x555, 0x55 at 0x2AA and 0x30 at any address. This sets to 0xFF every byte whose address bits [ADDR_W-1:SECT_W] match that address. All other bytes are unchanged.
- R5: The same erase preamble followed by 0x10 at 0x555 sets every byte of the array to 0xFF.
- R6: After the unlock pair, 0x90 at 0x555 enters ID mode. In ID mode a read at address 0 returns MFR_ID (default 0x01), a read at address 1 returns DEV_ID (default 0xA4), and a read at any other address returns 0x00. Writes other than 0xF0 leave ID mode in place.
- R7: A write of 0xF0 at any address while not busy returns the sequencer to idle and array-read mode from any state. This includes the armed-program state, where the 0xF0 write programs nothing.
- R8: busy_o rises on the edge that takes the operation's last write. It stays high for PROG_CYC cycles after a program, 2^SECT_W + ERASE_CYC cycles after a sector erase, and 2^ADDR_W + ERASE_CYC cycles after a chip erase.
- R9: A read taken while busy returns a byte with every bit 0 except bit 6. Bit 6 inverts on each such read, and the first busy read after reset returns 0x40.
- R10: Writes taken while busy have no effect, including 0xF0 and complete command sequences. They change neither the array nor the mode that holds after the operation.
- R11: rdata_o is loaded on the edge that samples re_i and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, one cycle per bus write |
| re_i | input | 1 | Read strobe, one cycle per bus read |
| addr_i | input | ADDR_W | Byte address for the read or write |
| wdata_i | input | 8 | Write data or command code |
| rdata_o | output | 8 | Registered read data: array, ID or status byte |
| busy_o | output | 1 | High while a program or erase runs |

## Verification
The assertions assume that we_i and re_i are never high in the same cycle, and that each strobe lasts exactly one cycle with addr_i and wdata_i valid alongside it. Under those assumptions the status-byte mask and the hold of rdata_o between reads are meaningful. The bench drives every strobe from a task that raises it at a falling edge, drops it one cycle later and leaves an idle cycle before the next strobe, so reads and writes never overlap. The array has no reset, so the stimulus opens with a chip erase before any read-back of array data.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] UNLK_A = 11'h555;
  localparam logic [CMD_AW-1:0] UNLK_B = 11'h2AA;

  localparam logic [7:0] C_UNL1  = 8'hAA;
  localparam logic [7:0] C_UNL2  = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ERASE = 8'h80;
  localparam logic [7:0] C_ID    = 8'h90;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_RESET = 8'hF0;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_CMD, S_ERA_ARM, S_ERA_UNL1, S_ERA_CMD, S_PROG_ARM, S_ID
  } seq_state_e;
endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              busy_i,
  input  logic [CMD_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output seq_state_e        state_o,
  output logic              prog_o,
  output logic              esect_o,
  output logic              echip_o
);
  seq_state_e st_q, st_d;
  logic at_a, at_b;

  assign at_a = (addr_i == UNLK_A);
  assign at_b = (addr_i == UNLK_B);

  always_comb begin
    st_d    = st_q;
    prog_o  = 1'b0;
    esect_o = 1'b0;
    echip_o = 1'b0;
    if (we_i && !busy_i) begin
      if (wdata_i == C_RESET) begin
        st_d = S_IDLE;
      end else begin
        unique case (st_q)
          S_IDLE:     st_d = (at_a && wdata_i == C_UNL1) ? S_UNL1 : S_IDLE;
          S_UNL1:     st_d = (at_b && wdata_i == C_UNL2) ? S_CMD : S_IDLE;
          S_CMD: begin
            st_d = S_IDLE;
            if (at_a) begin
              if (wdata_i == C_PROG)       st_d = S_PROG_ARM;
              else if (wdata_i == C_ERASE) st_d = S_ERA_ARM;
              else if (wdata_i == C_ID)    st_d = S_ID;
            end
          end
          S_ERA_ARM:  st_d = (at_a && wdata_i == C_UNL1) ? S_ERA_UNL1 : S_IDLE;
          S_ERA_UNL1: st_d = (at_b && wdata_i == C_UNL2) ? S_ERA_CMD : S_IDLE;
          S_ERA_CMD: begin
            st_d    = S_IDLE;
            esect_o = (wdata_i == C_SECT);
            echip_o = at_a && (wdata_i == C_CHIP);
          end
          S_PROG_ARM: begin
            st_d   = S_IDLE;
            prog_o = 1'b1;
          end
          S_ID:       st_d = S_ID;
          default:    st_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int PROG_CYC = 4,
  parameter int SECT_LEN = 272,
  parameter int CHIP_LEN = 2064
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prog_i,
  input  logic esect_i,
  input  logic echip_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CHIP_LEN + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (prog_i)       cnt_q <= CNT_W'(PROG_CYC);
    else if (esect_i)      cnt_q <= CNT_W'(SECT_LEN);
    else if (echip_i)      cnt_q <= CNT_W'(CHIP_LEN);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 11,
  parameter int SECT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              esect_i,
  input  logic              echip_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] SECT_N = (ADDR_W+1)'(1) << SECT_W;
  localparam logic [ADDR_W:0] CHIP_N = (ADDR_W+1)'(1) << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W:0]   left_q;

  // erase sweep: one byte per cycle from the range base
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      left_q <= '0;
    end else if (esect_i) begin
      ptr_q  <= {addr_i[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
      left_q <= SECT_N;
    end else if (echip_i) begin
      ptr_q  <= '0;
      left_q <= CHIP_N;
    end else if (left_q != '0) begin
      ptr_q  <= ptr_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (prog_i)              mem[addr_i] <= mem[addr_i] & wdata_i;
    else if (left_q != '0)   mem[ptr_q]  <= 8'hFF;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 11,
  parameter int         SECT_W    = 8,
  parameter int         PROG_CYC  = 4,
  parameter int         ERASE_CYC = 16,
  parameter logic [7:0] MFR_ID    = 8'h01,
  parameter logic [7:0] DEV_ID    = 8'hA4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o
);
  localparam int SECT_LEN = (1 << SECT_W) + ERASE_CYC;
  localparam int CHIP_LEN = (1 << ADDR_W) + ERASE_CYC;

  seq_state_e st;
  logic       prog_req, esect_req, echip_req;
  logic [7:0] arr_rd, id_byte;
  logic [7:0] rdata_q;
  logic       tog_q;

  flash_seq_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .busy_i  (busy_o),
    .addr_i  (addr_i[CMD_AW-1:0]),
    .wdata_i (wdata_i),
    .state_o (st),
    .prog_o  (prog_req),
    .esect_o (esect_req),
    .echip_o (echip_req)
  );

  flash_busy_timer #(
    .PROG_CYC (PROG_CYC),
    .SECT_LEN (SECT_LEN),
    .CHIP_LEN (CHIP_LEN)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prog_i  (prog_req),
    .esect_i (esect_req),
    .echip_i (echip_req),
    .busy_o  (busy_o)
  );

  flash_array #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W)
  ) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prog_i  (prog_req),
    .esect_i (esect_req),
    .echip_i (echip_req),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (arr_rd)
  );

  always_comb begin
    if (addr_i == '0)                 id_byte = MFR_ID;
    else if (addr_i == ADDR_W'(1))    id_byte = DEV_ID;
    else                              id_byte = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= 8'h00;
      tog_q   <= 1'b0;
    end else if (re_i) begin
      if (busy_o) begin
        tog_q   <= ~tog_q;
        rdata_q <= {1'b0, ~tog_q, 6'b0};
      end else if (st == S_ID) begin
        rdata_q <= id_byte;
      end else begin
        rdata_q <= arr_rd;
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       re_i,
  input logic       busy_i,
  input seq_state_e state_i,
  input logic       prog_i,
  input logic       esect_i,
  input logic       echip_i,
  input logic [7:0] rdata_i
);
  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_i, esect_i, echip_i}));                                  // R4
  AST_PROG_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> busy_i);                                                     // R8
  AST_ERASE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esect_i || echip_i) |=> busy_i);                                       // R8
  AST_NO_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !(prog_i || esect_i || echip_i));                            // R10
  AST_STATE_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(state_i));                                           // R10
  AST_STATUS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && re_i) |=> ((rdata_i & 8'hBF) == 8'h00));                     // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_i));                                            // R11
  AST_IDLE_AFTER_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i || esect_i || echip_i) |=> (state_i == S_IDLE));                // R3
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .re_i    (re_i),
  .busy_i  (busy_o),
  .state_i (st),
  .prog_i  (prog_req),
  .esect_i (esect_req),
  .echip_i (echip_req),
  .rdata_i (rdata_o)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
  localparam int ADDR_W    = 11;
  localparam int SECT_W    = 8;
  localparam int PROG_CYC  = 4;
  localparam int ERASE_CYC = 16;
  localparam int NV        = 82;

  // vector: {op[1:0], addr[10:0], data[7:0], req[3:0]}; op 0 write, 1 read-check, 2 wait
  function automatic logic [24:0] v_wr(logic [10:0] a, logic [7:0] d, logic [3:0] r);
    return {2'd0, a, d, r};
  endfunction
  function automatic logic [24:0] v_rd(logic [10:0] a, logic [7:0] e, logic [3:0] r);
    return {2'd1, a, e, r};
  endfunction
  function automatic logic [24:0] v_wt();
    return {2'd2, 11'h0, 8'h0, 4'd0};
  endfunction

  localparam logic [24:0] VEC [NV] = '{
    // R5 chip erase
    v_wr(11'h555,8'hAA,5), v_wr(11'h2AA,8'h55,5), v_wr(11'h555,8'h80,5),
    v_wr(11'h555,8'hAA,5), v_wr(11'h2AA,8'h55,5), v_wr(11'h555,8'h10,5), v_wt(),
    v_rd(11'h000,8'hFF,5), v_rd(11'h7FF,8'hFF,5), v_rd(11'h400,8'hFF,5),
    // R3 program, then AND program
    v_wr(11'h555,8'hAA,3), v_wr(11'h2AA,8'h55,3), v_wr(11'h555,8'hA0,3), v_wr(11'h123,8'h5A,3), v_wt(),
    v_rd(11'h123,8'h5A,3),
    v_wr(11'h555,8'hAA,3), v_wr(11'h2AA,8'h55,3), v_wr(11'h555,8'hA0,3), v_wr(11'h123,8'h0F,3), v_wt(),
    v_rd(11'h123,8'h0A,3),
    // R6 ID mode, R7 exit
    v_wr(11'h555,8'hAA,6), v_wr(11'h2AA,8'h55,6), v_wr(11'h555,8'h90,6),
    v_rd(11'h000,8'h01,6), v_rd(11'h001,8'hA4,6), v_rd(11'h002,8'h00,6),
    v_wr(11'h0AA,8'h12,6), v_rd(11'h000,8'h01,6),
    v_wr(11'h000,8'hF0,7), v_rd(11'h000,8'hFF,7), v_rd(11'h123,8'h0A,7),
    // R2 broken unlock
    v_wr(11'h555,8'hAA,2), v_wr(11'h2AA,8'h00,2), v_wr(11'h555,8'hA0,2), v_wr(11'h123,8'h00,2), v_wt(),
    v_rd(11'h123,8'h0A,2),
    // setup for sector erase
    v_wr(11'h555,8'hAA,3), v_wr(11'h2AA,8'h55,3), v_wr(11'h555,8'hA0,3), v_wr(11'h200,8'h33,3), v_wt(),
    v_wr(11'h555,8'hAA,3), v_wr(11'h2AA,8'h55,3), v_wr(11'h555,8'hA0,3), v_wr(11'h1FF,8'h44,3), v_wt(),
    // R2 broken erase preamble
    v_wr(11'h555,8'hAA,2), v_wr(11'h2AA,8'h55,2), v_wr(11'h555,8'h80,2),
    v_wr(11'h555,8'h00,2), v_wr(11'h2AA,8'h55,2), v_wr(11'h2AB,8'h30,2), v_wt(),
    v_rd(11'h200,8'h33,2),
    // R4 sector erase
    v_wr(11'h555,8'hAA,4), v_wr(11'h2AA,8'h55,4), v_wr(11'h555,8'h80,4),
    v_wr(11'h555,8'hAA,4), v_wr(11'h2AA,8'h55,4), v_wr(11'h2AB,8'h30,4), v_wt(),
    v_rd(11'h200,8'hFF,4), v_rd(11'h2FF,8'hFF,4), v_rd(11'h1FF,8'h44,4),
    v_rd(11'h300,8'hFF,4), v_rd(11'h123,8'h0A,4),
    // R7 reset code in armed-program state
    v_wr(11'h555,8'hAA,7), v_wr(11'h2AA,8'h55,7), v_wr(11'h555,8'hA0,7), v_wr(11'h1FF,8'hF0,7),
    v_wr(11'h1FF,8'h00,7), v_wt(), v_rd(11'h1FF,8'h44,7),
    // R2 wrong unlock address
    v_wr(11'h554,8'hAA,2), v_wr(11'h2AA,8'h55,2), v_wr(11'h555,8'hA0,2), v_wr(11'h1FF,8'h00,2), v_wt(),
    v_rd(11'h1FF,8'h44,2)
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic              re_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        wdata_i = '0;
  logic [7:0]        rdata_o;
  logic              busy_o;

  int n_chk = 0;
  int n_fail = 0;
  int busy_reads = 0;

  always #2 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_o(busy_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [10:0] a, logic [7:0] d);
    @(negedge clk); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); we_i = 1'b0;
  endtask

  task automatic rd(logic [10:0] a, output logic [7:0] q);
    @(negedge clk); re_i = 1'b1; addr_i = a;
    @(negedge clk); re_i = 1'b0; q = rdata_o;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  // count busy cycles seen at falling edges right after the launching write
  task automatic count_busy(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic erase_pre();
    unlock(); wr(11'h555, 8'h80); unlock();
  endtask

  task automatic busy_rd(string tag);
    logic [7:0] q;
    rd(11'h000, q);
    busy_reads++;
    chk(tag, q, (busy_reads % 2 == 1) ? 8'h40 : 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset busy_o", busy_o, 0);
    chk("R1 reset rdata_o", rdata_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [10:0] a;
      logic [7:0]  d;
      logic [3:0]  r;
      {op, a, d, r} = VEC[i];
      if (op == 2'd0) wr(a, d);
      else if (op == 2'd2) wait_idle();
      else begin
        rd(a, q);
        chk($sformatf("R%0d vector %0d", r, i), q, d);
      end
    end

    // R1 reset pulse taken in ID mode returns to array reads
    unlock(); wr(11'h555, 8'h90);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    chk("R1 rdata after reset pulse", rdata_o, 8'h00);
    rd(11'h000, q);
    chk("R1 array read after reset pulse", q, 8'hFF);

    // R8 program busy length
    unlock(); wr(11'h555, 8'hA0); wr(11'h500, 8'hC3);
    count_busy(n);
    chk("R8 program busy cycles", n, PROG_CYC);
    rd(11'h500, q);
    chk("R3 program at 0x500", q, 8'hC3);

    // R8 sector erase busy length
    erase_pre(); wr(11'h500, 8'h30);
    count_busy(n);
    chk("R8 sector erase busy cycles", n, (1 << SECT_W) + ERASE_CYC);
    rd(11'h500, q);
    chk("R4 erased 0x500", q, 8'hFF);

    // R9 status toggling, R10 writes ignored while busy
    erase_pre(); wr(11'h600, 8'h30);
    busy_rd("R9 first busy read");
    busy_rd("R9 second busy read");
    busy_rd("R9 third busy read");
    wr(11'h000, 8'hF0);
    unlock(); wr(11'h555, 8'h90);
    unlock(); wr(11'h555, 8'hA0); wr(11'h123, 8'h00);
    wait_idle();
    rd(11'h000, q);
    chk("R10 no ID mode after busy writes", q, 8'hFF);
    rd(11'h123, q);
    chk("R10 no program from busy writes", q, 8'h0A);

    // R11 rdata holds without a read strobe
    repeat (5) @(negedge clk);
    chk("R11 rdata held", rdata_o, 8'h0A);

    // R9 during program busy
    unlock(); wr(11'h555, 8'hA0); wr(11'h7F0, 8'h81);
    busy_rd("R9 busy read during program");
    wait_idle();
    rd(11'h7F0, q);
    chk("R3 program at 0x7F0", q, 8'h81);

    // R8 chip erase busy length
    erase_pre(); wr(11'h555, 8'h10);
    count_busy(n);
    chk("R8 chip erase busy cycles", n, (1 << ADDR_W) + ERASE_CYC);
    rd(11'h123, q);
    chk("R5 chip erase 0x123", q, 8'hFF);
    rd(11'h7F0, q);
    chk("R5 chip erase 0x7F0", q, 8'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule